// File: doc/BRIEF.md
# Power Management Wake Event Register

This block is a single 32-bit control and status register that gathers wake sources and drives an active-low power management event output. One source is a link-fail level on general-purpose input pin 0. Software chooses whether that pin counts as a wake source and which level of it means "link failed". The other source is a one-cycle wakeup pulse from the receive path. Each source has a sticky event flag. The event output stays asserted while either flag is set.

The flags cannot be cleared by a register write. Both clear only when the PCI power management logic pulses its status-clear strobe. The register also holds one writable bit that drives the external PHY reset pin directly. The register port is a plain write strobe with write data, and read data that always shows the current register contents.

Top module: `pm_wake_regs`

## Requirements
- R1: After reset every field reads zero and `pme_n` is high. Bits 31:6 always read zero.
- R2: Bit 5 can be written and read back, and `phy_rst_out` follows it one clock after the write. No other source asserts `phy_rst_out`.
- R3: Bit 4 is read-only and shows `gpio_link_in` through a two-flop synchronizer. A change on the pin shows up in bit 4 two clock edges later.
- R4: Bit 3 is the link-fail enable. While it is 0, the pin never sets the link-fail flag, whatever its level.
- R5: Bit 2 selects the pin polarity. With bit 2 = 0 a high synchronized level means link fail. With bit 2 = 1 a low level means link fail.
- R6: Bit 1 is the sticky link-fail flag. It sets on the clock edge after bit 4 shows the active level while bit 3 is set, and then holds until a clear.
- R7: Bit 0 is the sticky receive-wakeup flag. It sets on the edge that samples `rx_wake_pulse` high and then holds until a clear.
- R8: `pme_n` is low exactly one clock after either flag is set. It returns high one clock after both flags are zero.
- R9: A `pme_stat_clr` pulse zeroes both flags on that edge. If a set condition and the clear arrive in the same cycle, the clear wins. A link-fail level that is still active sets bit 1 again on the following edge.
- R10: Writes to bits 4, 1, 0 and 31:6 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the register |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Current register contents |
| gpio_link_in | input | 1 | Raw link-fail input from general-purpose pin 0, asynchronous |
| rx_wake_pulse | input | 1 | Wakeup pulse from the receive path, one cycle |
| pme_stat_clr | input | 1 | Strobe that clears both event flags |
| phy_rst_out | output | 1 | External PHY reset pin |
| pme_n | output | 1 | Active-low power management event |

## Verification
The assertions assume that `rx_wake_pulse` and `pme_stat_clr` are synchronous to `clk`. They also assume that the register reads back at once through `reg_rd_data`, with no wait states. The bench changes every input, including the asynchronous pin, just after the falling edge, so each value is stable before the next rising edge. It releases reset away from an edge. Every flag check starts from a known state: the flags cleared, and the pin held for at least two cycles so the synchronizer has settled.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
   // Field positions, as software sees them
   localparam int unsigned FLD_WAKE_EVT  = 0;
   localparam int unsigned FLD_LINK_EVT  = 1;
   localparam int unsigned FLD_LINK_POL  = 2;
   localparam int unsigned FLD_LINK_EN   = 3;
   localparam int unsigned FLD_LINK_LIVE = 4;
   localparam int unsigned FLD_PHY_RST   = 5;
   localparam int unsigned FLD_TOP       = 5;

   localparam int unsigned NUM_SRC  = 2;
   localparam int unsigned SRC_WAKE = 0;
   localparam int unsigned SRC_LINK = 1;

   typedef struct packed {
      logic phy_rst;
      logic link_en;
      logic link_pol;
   } pmw_ctrl_t;
endpackage

// File: rtl/pmw_sync.sv
module pmw_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pmw_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q[s] <= RST_VAL;
         end else if (s == 0) begin
            chain_q[s] <= d_i;
         end else begin
            chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pmw_evt_latch.sv
module pmw_evt_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   // clear has priority over set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (clr_i) q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
   end
endmodule

// File: rtl/pm_wake_regs.sv
module pm_wake_regs
   import pmw_pkg::*;
#(
   parameter int unsigned REG_W       = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr_en,
   input  logic [REG_W-1:0] reg_wr_data,
   output logic [REG_W-1:0] reg_rd_data,
   input  logic             gpio_link_in,
   input  logic             rx_wake_pulse,
   input  logic             pme_stat_clr,
   output logic             phy_rst_out,
   output logic             pme_n
);
   localparam int unsigned USED_W = FLD_TOP + 1;

   if (REG_W < USED_W) begin : g_bad_width
      $error("pm_wake_regs: REG_W too small for the defined fields");
   end

   pmw_ctrl_t           ctrl_q;
   logic                link_live;
   logic                link_active;
   logic [NUM_SRC-1:0]  src_set;
   logic [NUM_SRC-1:0]  evt_q;
   logic                pme_n_q;

   // software-writable control fields
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (reg_wr_en) begin
         ctrl_q.phy_rst  <= reg_wr_data[FLD_PHY_RST];
         ctrl_q.link_en  <= reg_wr_data[FLD_LINK_EN];
         ctrl_q.link_pol <= reg_wr_data[FLD_LINK_POL];
      end
   end

   pmw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) link_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (gpio_link_in),
      .q_o   (link_live)
   );

   // polarity 0: high means fail, polarity 1: low means fail
   assign link_active        = ctrl_q.link_en & (link_live ^ ctrl_q.link_pol);
   assign src_set[SRC_WAKE]  = rx_wake_pulse;
   assign src_set[SRC_LINK]  = link_active;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      pmw_evt_latch evt_i (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (src_set[i]),
         .clr_i (pme_stat_clr),
         .q_o   (evt_q[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pme_n_q <= 1'b1;
      else        pme_n_q <= ~(|evt_q);
   end

   assign pme_n       = pme_n_q;
   assign phy_rst_out = ctrl_q.phy_rst;

   always_comb begin
      reg_rd_data                = '0;
      reg_rd_data[FLD_WAKE_EVT]  = evt_q[SRC_WAKE];
      reg_rd_data[FLD_LINK_EVT]  = evt_q[SRC_LINK];
      reg_rd_data[FLD_LINK_POL]  = ctrl_q.link_pol;
      reg_rd_data[FLD_LINK_EN]   = ctrl_q.link_en;
      reg_rd_data[FLD_LINK_LIVE] = link_live;
      reg_rd_data[FLD_PHY_RST]   = ctrl_q.phy_rst;
   end

   logic unused_wr_bits;
   assign unused_wr_bits = ^{reg_wr_data[REG_W-1:USED_W], reg_wr_data[FLD_LINK_LIVE],
                             reg_wr_data[FLD_LINK_EVT], reg_wr_data[FLD_WAKE_EVT]};
endmodule

// File: rtl/pmw_checker.sv
module pmw_checker #(
   parameter int unsigned REG_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr_en,
   input logic [REG_W-1:0] reg_wr_data,
   input logic [REG_W-1:0] reg_rd_data,
   input logic             rx_wake_pulse,
   input logic             pme_stat_clr,
   input logic             phy_rst_out,
   input logic             pme_n
);
   assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_data[REG_W-1:6] == '0);

   assert_phy_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> (phy_rst_out == $past(reg_wr_data[5])));

   assert_phy_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr_en |=> $stable(phy_rst_out));

   assert_link_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_rd_data[3] && !reg_rd_data[1] && !reg_wr_en) |=> !reg_rd_data[1]);

   assert_link_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_data[1] && !pme_stat_clr) |=> reg_rd_data[1]);

   assert_wake_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_wake_pulse && !pme_stat_clr) |=> reg_rd_data[0]);

   assert_wake_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_data[0] && !pme_stat_clr) |=> reg_rd_data[0]);

   assert_pme_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|reg_rd_data[1:0]) |=> !pme_n);

   assert_pme_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_data[1:0] == 2'b00) |=> pme_n);

   assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pme_stat_clr |=> (reg_rd_data[1:0] == 2'b00));

   logic unused_chk;
   assign unused_chk = ^{reg_wr_data[REG_W-1:6], reg_wr_data[4:0]};
endmodule

bind pm_wake_regs pmw_checker #(.REG_W(REG_W)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_wr_en     (reg_wr_en),
   .reg_wr_data   (reg_wr_data),
   .reg_rd_data   (reg_rd_data),
   .rx_wake_pulse (rx_wake_pulse),
   .pme_stat_clr  (pme_stat_clr),
   .phy_rst_out   (phy_rst_out),
   .pme_n         (pme_n)
);

// File: tb/pm_wake_regs_tb_top.sv
`timescale 1ns/1ps
module pm_wake_regs_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wr_data = '0;
   logic [31:0] reg_rd_data;
   logic        gpio_link_in = 1'b0;
   logic        rx_wake_pulse = 1'b0;
   logic        pme_stat_clr = 1'b0;
   logic        phy_rst_out;
   logic        pme_n;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   pm_wake_regs dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
      .reg_rd_data(reg_rd_data), .gpio_link_in(gpio_link_in),
      .rx_wake_pulse(rx_wake_pulse), .pme_stat_clr(pme_stat_clr),
      .phy_rst_out(phy_rst_out), .pme_n(pme_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      reg_wr_en = 1'b1; reg_wr_data = d;
      tick();
      reg_wr_en = 1'b0; reg_wr_data = '0;
   endtask

   task automatic clear_pulse();
      pme_stat_clr = 1'b1;
      tick();
      pme_stat_clr = 1'b0;
   endtask

   // config off, pin settled, flags cleared, pme_n back high
   task automatic settle(input logic pin);
      wr(32'h0);
      gpio_link_in = pin;
      tick(3);
      clear_pulse();
      tick();
   endtask

   task automatic t_reset();
      chk("R1 reset read", reg_rd_data, 32'h0);
      chk("R1 reset pme_n", {31'b0, pme_n}, 32'h1);
      chk("R1 reset phy", {31'b0, phy_rst_out}, 32'h0);
   endtask

   task automatic t_phy();
      wr(32'h20);
      chk("R2 phy set", {31'b0, phy_rst_out}, 32'h1);
      chk("R2 phy readback", reg_rd_data, 32'h20);
      tick(2);
      chk("R2 phy holds", {31'b0, phy_rst_out}, 32'h1);
      wr(32'h0);
      chk("R2 phy cleared", {31'b0, phy_rst_out}, 32'h0);
   endtask

   task automatic t_ignore();
      settle(1'b1);
      // pol=1 and pin high: link inactive
      wr(32'hFFFF_FFFF);
      chk("R10 write all ones", reg_rd_data, 32'h3C);
      chk("R10 pme_n untouched", {31'b0, pme_n}, 32'h1);
      wr(32'h0);
   endtask

   task automatic t_link_high();
      settle(1'b0);
      wr(32'h08);
      gpio_link_in = 1'b1;
      tick();
      chk("R3 live after one edge", {31'b0, reg_rd_data[4]}, 32'h0);
      tick();
      chk("R3 live after two edges", {31'b0, reg_rd_data[4]}, 32'h1);
      chk("R6 flag not yet set", {31'b0, reg_rd_data[1]}, 32'h0);
      tick();
      chk("R6 flag set", {31'b0, reg_rd_data[1]}, 32'h1);
      chk("R8 pme_n not yet low", {31'b0, pme_n}, 32'h1);
      tick();
      chk("R8 pme_n low", {31'b0, pme_n}, 32'h0);
      // clear while level still active
      pme_stat_clr = 1'b1;
      tick();
      pme_stat_clr = 1'b0;
      chk("R9 clear wins", {31'b0, reg_rd_data[1]}, 32'h0);
      chk("R8 pme_n lags clear", {31'b0, pme_n}, 32'h0);
      tick();
      chk("R9 level resets flag", {31'b0, reg_rd_data[1]}, 32'h1);
      chk("R8 pme_n pulses high", {31'b0, pme_n}, 32'h1);
      gpio_link_in = 1'b0;
      tick(3);
      chk("R6 flag sticky after pin drop", {31'b0, reg_rd_data[1]}, 32'h1);
      clear_pulse();
      chk("R9 flag cleared", {31'b0, reg_rd_data[1]}, 32'h0);
      tick();
      chk("R8 pme_n high after clear", {31'b0, pme_n}, 32'h1);
   endtask

   task automatic t_link_low();
      settle(1'b1);
      wr(32'h0C);
      tick(2);
      chk("R5 high ignored when active low", {31'b0, reg_rd_data[1]}, 32'h0);
      gpio_link_in = 1'b0;
      tick(3);
      chk("R5 low sets flag", {31'b0, reg_rd_data[1]}, 32'h1);
      settle(1'b0);
   endtask

   task automatic t_disabled();
      settle(1'b0);
      wr(32'h04);
      tick(4);
      chk("R4 disabled low", {31'b0, reg_rd_data[1]}, 32'h0);
      gpio_link_in = 1'b1;
      wr(32'h00);
      tick(4);
      chk("R4 disabled high", {31'b0, reg_rd_data[1]}, 32'h0);
      chk("R4 pme_n stays high", {31'b0, pme_n}, 32'h1);
      settle(1'b0);
   endtask

   task automatic t_wake();
      settle(1'b0);
      rx_wake_pulse = 1'b1;
      tick();
      rx_wake_pulse = 1'b0;
      chk("R7 wake set", {31'b0, reg_rd_data[0]}, 32'h1);
      chk("R8 pme_n lags wake", {31'b0, pme_n}, 32'h1);
      tick();
      chk("R8 pme_n low on wake", {31'b0, pme_n}, 32'h0);
      wr(32'h0000_0003);
      tick(3);
      chk("R7 wake sticky", {31'b0, reg_rd_data[0]}, 32'h1);
      chk("R10 write cannot clear flags", reg_rd_data[1:0], 32'h1);
      clear_pulse();
      chk("R9 wake cleared", {31'b0, reg_rd_data[0]}, 32'h0);
      tick();
      chk("R8 pme_n high after wake clear", {31'b0, pme_n}, 32'h1);
      rx_wake_pulse = 1'b1; pme_stat_clr = 1'b1;
      tick();
      rx_wake_pulse = 1'b0; pme_stat_clr = 1'b0;
      chk("R9 clear beats wake", {31'b0, reg_rd_data[0]}, 32'h0);
      tick();
      chk("R9 pme_n stays high", {31'b0, pme_n}, 32'h1);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      #7.3 rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_phy();
      t_ignore();
      t_link_high();
      t_link_low();
      t_disabled();
      t_wake();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule